// File: doc/BRIEF.md
# Multi-Channel Phase Accumulator Bank

This block keeps one phase accumulator for each channel ID in an internal memory. A stream of beats enters the block. Each beat carries a channel ID, a phase increment, an offset word and a user sideband. For each beat the block reads the accumulator stored for that ID and adds the phase offset to it. It emits the sum together with the ID and the sideband. It then stores the accumulator plus the increment, so the increment only takes effect on the next visit to that ID.

The offset word also carries a clear flag. When the flag is set, the stored accumulator is treated as zero for that beat. A downstream stage, such as a sine lookup, can then turn the phase stream into waveforms.

The block has no backpressure. Each valid beat produces exactly one output beat two clock cycles later. A beat may use the same ID as the beat just before it. In that case the block forwards the pending write-back value instead of the stale memory read, so back-to-back visits still see every earlier increment.

Top module: `phase_acc_bank`

## Requirements
- R1: Each input beat with `in_valid` high gives `out_valid` high exactly two clock cycles later. `out_id` and `out_user` equal that beat's `in_id` and `in_user`. Cycles without an input beat give `out_valid` low.
- R2: On the first visit to an ID after reset, the stored accumulator is zero. The emitted phase equals the offset field, and the stored value becomes the increment.
- R3: For a beat without the clear flag, `out_phase` = stored + offset, where offset is `in_offs_word[PHASE_W-1:0]`. The stored value then becomes stored + increment.
- R4: A beat changes only the accumulator of its own ID. The accumulators of all other IDs are left as they were.
- R5: The clear flag is bit `PHASE_W` of `in_offs_word`. When it is set, `out_phase` equals the offset field alone and the stored value becomes the increment.
- R6: When two consecutive beats use the same ID, the second beat sees the value written back by the first.
- R7: While `rst_n` is low, and on the first cycle after it is released, `out_valid` is low. After a reset every accumulator reads as zero.
- R8: Every addition wraps modulo 2^`PHASE_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat strobe |
| in_id | input | ID_W | Channel ID of the beat |
| in_incr | input | PHASE_W | Phase increment for the next visit |
| in_offs_word | input | PHASE_W+1 | Bit PHASE_W is the clear flag; the bits below it are the phase offset |
| in_user | input | USER_W | Sideband carried alongside the beat |
| out_valid | output | 1 | Output beat strobe |
| out_id | output | ID_W | Channel ID, delayed to match the phase |
| out_phase | output | PHASE_W | Stored accumulator plus offset |
| out_user | output | USER_W | Sideband, delayed to match the phase |

## Verification
The main function is exercised with several input patterns:
- Random beats over a small set of IDs, so that repeats both with a gap and without one are frequent. These separate the forwarding path from the plain memory read.
- Sparse traffic with idle gaps. This shows that an accumulator moves only on its own visits.
- A directed interleave of two IDs. This shows that one ID's writes leave the other untouched.
- Large increments and offsets, which force wrap-around.
- Clear-flag beats and a mid-run reset, which separate the emitted-offset-only path and the return to zero.

// File: rtl/phase_acc_pkg.sv
// Shared constants and types for the phase accumulator bank.
// Assumes: nothing beyond IEEE 1800-2017.
package phase_acc_pkg;

    // Default sizes used by the top module.
    localparam int DEF_PHASE_W = 16;
    localparam int DEF_ID_W    = 8;
    localparam int DEF_USER_W  = 4;

    // Where stage 2 takes its current accumulator value from.
    typedef enum logic [1:0] {
        SRC_MEM = 2'd0,   // registered memory read
        SRC_FWD = 2'd1,   // write-back of the previous beat (same ID)
        SRC_CLR = 2'd2    // clear flag: treated as zero
    } acc_src_e;

endpackage

// File: rtl/pab_acc_mem.sv
// Accumulator storage: one word per channel ID, with a synchronous read.
// The read returns the old contents when a write hits the same entry on the
// same edge. Entries not written since reset read as zero; this is done with
// per-entry written flags, so the data array itself needs no reset.
// Assumes: one read port and one write port, both driven on every edge.
module pab_acc_mem #(
    parameter int PHASE_W = 16,
    parameter int ID_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [ID_W-1:0]    rd_id,
    output logic [PHASE_W-1:0] rd_data,
    input  logic               wr_en,
    input  logic [ID_W-1:0]    wr_id,
    input  logic [PHASE_W-1:0] wr_data
);
    localparam int DEPTH = 1 << ID_W;

    logic [PHASE_W-1:0] store [DEPTH];
    logic [DEPTH-1:0]   written;

    // Data array write; no reset needed because the written flags mask reads.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_id] <= wr_data;
        end
    end

    // Written flags: cleared by reset, set by each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            written <= '0;
        end else if (wr_en) begin
            written[wr_id] <= 1'b1;
        end
    end

    // Registered read; an entry that has never been written returns zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= written[rd_id] ? store[rd_id] : '0;
        end
    end

endmodule

// File: rtl/pab_fwd_sel.sv
// Hazard forwarding for read-modify-write on consecutive beats.
// It keeps the ID and value of the write made on the last edge. When the beat
// now in stage 2 has the same ID, its memory read was taken on that same edge
// and is stale, so the kept value is used in its place.
// Assumes: the memory read is registered, with exactly one cycle of latency.
module pab_fwd_sel
    import phase_acc_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int ID_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_valid,
    input  logic [ID_W-1:0]    s_id,
    input  logic               s_clr,
    input  logic [PHASE_W-1:0] mem_data,
    input  logic [PHASE_W-1:0] wb_data,
    output logic [PHASE_W-1:0] cur_acc
);
    logic               last_vld;
    logic [ID_W-1:0]    last_id;
    logic [PHASE_W-1:0] last_data;
    acc_src_e           src;

    // Remember the write made on this edge, for use by the next beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_vld  <= 1'b0;
            last_id   <= '0;
            last_data <= '0;
        end else begin
            last_vld  <= s_valid;
            last_id   <= s_id;
            last_data <= wb_data;
        end
    end

    // Pick the source of the current accumulator value.
    always_comb begin
        if (s_clr) begin
            src = SRC_CLR;
        end else if (last_vld && last_id == s_id) begin
            src = SRC_FWD;
        end else begin
            src = SRC_MEM;
        end
    end

    // Drive the selected value.
    always_comb begin
        unique case (src)
            SRC_CLR: cur_acc = '0;
            SRC_FWD: cur_acc = last_data;
            default: cur_acc = mem_data;
        endcase
    end

endmodule

// File: rtl/pab_phase_calc.sv
// Arithmetic for stage 2: emitted phase = current + offset, and
// next stored value = current + increment. Both wrap modulo 2^PHASE_W.
// Assumes: the clear flag has already been folded into cur_acc.
module pab_phase_calc #(
    parameter int PHASE_W = 16
) (
    input  logic [PHASE_W-1:0] cur_acc,
    input  logic [PHASE_W-1:0] incr,
    input  logic [PHASE_W-1:0] offs,
    output logic [PHASE_W-1:0] phase,
    output logic [PHASE_W-1:0] next_acc
);
    // Two independent adders of the same width; the carry out is dropped.
    always_comb begin
        phase    = cur_acc + offs;
        next_acc = cur_acc + incr;
    end

endmodule

// File: rtl/phase_acc_bank.sv
// Multi-channel phase accumulator bank.
// Stage 1 registers the beat and starts the accumulator read.
// Stage 2 selects the current value (memory, forwarded or cleared), writes
// back current + increment, and registers the output phase.
// Latency is two cycles; there is no backpressure.
// Assumes: one beat per cycle at most; the offset word has the clear flag
// in bit PHASE_W.
module phase_acc_bank
    import phase_acc_pkg::*;
#(
    parameter int PHASE_W = DEF_PHASE_W,
    parameter int ID_W    = DEF_ID_W,
    parameter int USER_W  = DEF_USER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ID_W-1:0]    in_id,
    input  logic [PHASE_W-1:0] in_incr,
    input  logic [PHASE_W:0]   in_offs_word,
    input  logic [USER_W-1:0]  in_user,
    output logic               out_valid,
    output logic [ID_W-1:0]    out_id,
    output logic [PHASE_W-1:0] out_phase,
    output logic [USER_W-1:0]  out_user
);
    localparam int CLR_BIT = PHASE_W;

    logic               s1_valid;
    logic [ID_W-1:0]    s1_id;
    logic [PHASE_W-1:0] s1_incr;
    logic [PHASE_W-1:0] s1_offs;
    logic               s1_clr;
    logic [USER_W-1:0]  s1_user;

    logic [PHASE_W-1:0] mem_rd;
    logic [PHASE_W-1:0] cur_acc;
    logic [PHASE_W-1:0] phase_c;
    logic [PHASE_W-1:0] next_c;

    // Stage 1: capture the beat and split the offset word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_id    <= '0;
            s1_incr  <= '0;
            s1_offs  <= '0;
            s1_clr   <= 1'b0;
            s1_user  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_id    <= in_id;
            s1_incr  <= in_incr;
            s1_offs  <= in_offs_word[PHASE_W-1:0];
            s1_clr   <= in_offs_word[CLR_BIT];
            s1_user  <= in_user;
        end
    end

    pab_acc_mem #(
        .PHASE_W (PHASE_W),
        .ID_W    (ID_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (in_valid),
        .rd_id   (in_id),
        .rd_data (mem_rd),
        .wr_en   (s1_valid),
        .wr_id   (s1_id),
        .wr_data (next_c)
    );

    pab_fwd_sel #(
        .PHASE_W (PHASE_W),
        .ID_W    (ID_W)
    ) u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_valid  (s1_valid),
        .s_id     (s1_id),
        .s_clr    (s1_clr),
        .mem_data (mem_rd),
        .wb_data  (next_c),
        .cur_acc  (cur_acc)
    );

    pab_phase_calc #(
        .PHASE_W (PHASE_W)
    ) u_calc (
        .cur_acc  (cur_acc),
        .incr     (s1_incr),
        .offs     (s1_offs),
        .phase    (phase_c),
        .next_acc (next_c)
    );

    // Stage 2 output register: phase with its matching ID and sideband.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_id    <= '0;
            out_phase <= '0;
            out_user  <= '0;
        end else begin
            out_valid <= s1_valid;
            out_id    <= s1_id;
            out_phase <= phase_c;
            out_user  <= s1_user;
        end
    end

endmodule

// File: rtl/phase_acc_bank_checker.sv
// Port-level properties of the accumulator bank, bound to the top module.
// A saturating count of cycles since reset keeps every $past inside the
// cycles that have passed since reset was released.
module phase_acc_bank_checker #(
    parameter int PHASE_W = 16,
    parameter int ID_W    = 8,
    parameter int USER_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [ID_W-1:0]    in_id,
    input logic [PHASE_W:0]   in_offs_word,
    input logic [USER_W-1:0]  in_user,
    input logic               out_valid,
    input logic [ID_W-1:0]    out_id,
    input logic [PHASE_W-1:0] out_phase,
    input logic [USER_W-1:0]  out_user
);
    logic [1:0] since_rst;

    // Count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1: valid appears exactly two cycles after an input beat.
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R1: ID and sideband travel with the beat.
    p_sideband_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && out_valid) |->
            (out_id == $past(in_id, 2) && out_user == $past(in_user, 2)));

    // R5: a cleared beat emits its offset field alone.
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(in_valid && in_offs_word[PHASE_W], 2)) |->
            (out_phase == $past(in_offs_word[PHASE_W-1:0], 2)));

    // R7: the first cycle after reset shows no output beat.
    p_rst_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd0) |-> !out_valid);

endmodule

bind phase_acc_bank phase_acc_bank_checker #(
    .PHASE_W (PHASE_W),
    .ID_W    (ID_W),
    .USER_W  (USER_W)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_id        (in_id),
    .in_offs_word (in_offs_word),
    .in_user      (in_user),
    .out_valid    (out_valid),
    .out_id       (out_id),
    .out_phase    (out_phase),
    .out_user     (out_user)
);

// File: tb/phase_acc_bank_bench.sv
// Bench for the accumulator bank. A reference model is updated in beat order.
// Expected outputs go through a two-deep delay line and are compared at the
// falling edge.
module phase_acc_bank_bench;
    localparam int PW = 16;
    localparam int IW = 8;
    localparam int UW = 4;
    localparam int NID = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] in_id = '0;
    logic [PW-1:0] in_incr = '0;
    logic [PW:0]   in_offs_word = '0;
    logic [UW-1:0] in_user = '0;
    logic          out_valid;
    logic [IW-1:0] out_id;
    logic [PW-1:0] out_phase;
    logic [UW-1:0] out_user;

    always #10 clk = ~clk;   // 50 MHz

    phase_acc_bank #(.PHASE_W(PW), .ID_W(IW), .USER_W(UW)) u_phase_acc_bank (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id),
        .in_incr(in_incr), .in_offs_word(in_offs_word), .in_user(in_user),
        .out_valid(out_valid), .out_id(out_id), .out_phase(out_phase),
        .out_user(out_user)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [PW-1:0] model_acc [NID];
    bit            visited   [NID];
    bit            prev_v    = 1'b0;
    logic [IW-1:0] prev_id   = '0;

    // Two-stage delay line of expectations.
    bit d1_v = 0, d2_v = 0;
    logic [IW-1:0] d1_id, d2_id;
    logic [PW-1:0] d1_ph, d2_ph;
    logic [UW-1:0] d1_us, d2_us;
    string d1_tag = "R1", d2_tag = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NID; i++) begin
            model_acc[i] = '0;
            visited[i]   = 1'b0;
        end
        prev_v = 1'b0;
    endtask

    // One cycle: compare, shift, then drive a beat (or idle) and model it.
    task automatic step(input bit v, input logic [IW-1:0] id,
                        input logic [PW-1:0] incr, input logic [PW-1:0] offs,
                        input bit clr, input logic [UW-1:0] us, input string force_tag);
        logic [PW:0] sum;
        string tag;
        @(negedge clk);
        check(out_valid == d2_v, "R1", "out_valid", out_valid, d2_v);
        if (d2_v && out_valid) begin
            check(out_id == d2_id, "R1", "out_id", out_id, d2_id);
            check(out_user == d2_us, "R1", "out_user", out_user, d2_us);
            check(out_phase == d2_ph, d2_tag, "out_phase", out_phase, d2_ph);
        end
        d2_v = d1_v; d2_id = d1_id; d2_ph = d1_ph; d2_us = d1_us; d2_tag = d1_tag;
        in_valid = v; in_id = id; in_incr = incr;
        in_offs_word = {clr, offs}; in_user = us;
        d1_v = v && rst_n;
        if (d1_v) begin
            sum = {1'b0, model_acc[id]} + {1'b0, offs};
            if (clr) tag = "R5";
            else if (prev_v && prev_id == id) tag = "R6";
            else if (!visited[id]) tag = "R2";
            else if (sum[PW]) tag = "R8";
            else tag = "R3";
            if (force_tag != "") tag = force_tag;
            d1_id = id; d1_us = us; d1_tag = tag;
            d1_ph = clr ? offs : sum[PW-1:0];
            model_acc[id] = clr ? incr : model_acc[id] + incr;
            visited[id] = 1'b1;
        end
        prev_v = d1_v; prev_id = id;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, '0, '0, 0, '0, "");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        idle(3);
        // R7: reset state
        check(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        // R2: first visit emits the offset; R3: second visit adds the increment
        step(1, 8'd5, 16'h0100, 16'h0010, 0, 4'h1, "R2");
        idle(1);
        step(1, 8'd5, 16'h0100, 16'h0010, 0, 4'h2, "R3");
        // R4: another ID in between leaves ID 5 unchanged
        step(1, 8'd6, 16'h7777, 16'h0003, 0, 4'h3, "R4");
        step(1, 8'd6, 16'h7777, 16'h0003, 0, 4'h4, "R6");
        step(1, 8'd5, 16'h0100, 16'h0000, 0, 4'h5, "R4");
        // R6: a burst of back-to-back beats on one ID
        for (int i = 0; i < 4; i++) step(1, 8'd9, 16'h1234, 16'h0001, 0, 4'(i), "R6");
        // R8: wrap of both adders
        step(1, 8'd200, 16'hFFF0, 16'h0000, 0, 4'h6, "R2");
        step(1, 8'd200, 16'h0020, 16'hFFF8, 0, 4'h7, "R8");
        step(1, 8'd200, 16'h0000, 16'h0000, 0, 4'h8, "R8");
        // R5: clear, then check the stored value became the increment
        step(1, 8'd9, 16'h0042, 16'h0500, 1, 4'h9, "R5");
        idle(1);
        step(1, 8'd9, 16'h0000, 16'h0000, 0, 4'hA, "R5");
        // Random traffic over a few IDs with gaps
        for (int i = 0; i < 3000; i++) begin
            bit v = ($urandom % 4) != 0;
            logic [IW-1:0] id = ($urandom % 8 == 0) ? IW'($urandom) : IW'($urandom % 6);
            step(v, id, PW'($urandom), PW'($urandom), ($urandom % 16) == 0,
                 UW'($urandom), "");
        end
        // R7: mid-run reset returns all accumulators to zero
        idle(3);
        rst_n = 1'b0;
        model_reset();
        idle(2);
        check(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        idle(1);
        check(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
        step(1, 8'd5, 16'h0001, 16'h0033, 0, 4'hB, "R7");
        step(1, 8'd9, 16'h0001, 16'h0044, 0, 4'hC, "R7");
        idle(3);
        finish_run();
    end

endmodule